// File: doc/BRIEF.md
# Single-Bus Processor Control Sequencer

This block is the hardwired control unit of a small processor in which every register talks over one shared 8-bit bus, bundled with the datapath it steers. A step counter walks each instruction through numbered control steps. In each step a decoder enables at most one bus driver and any number of bus loads: program counter, memory address register, memory data register, instruction register, the ALU's operand latch Y and result register Z, and the register file. Incrementing the program counter has no adder of its own. The PC goes over the bus, the ALU adds one into Z, and Z comes back over the bus into the PC in the following step.

Memory sits outside. The block presents a one-cycle read request with the address taken from the address register. It then waits for a completion pulse that carries the read data, which is loaded into the data register. Any step that needs data from memory freezes the step counter until that completion has been seen, so memory may answer after any number of cycles. The instruction set has four instructions: load from a short direct address, register-to-register add, no-operation and halt.

Top module: `sbus_cpu`

## Requirements
- R1: When `rst_n` is low, the step counter goes to step 1, the PC to 0, `halted` to 0 and all four general registers to 0. No read is requested while reset is held.
- R2: In step 1, the PC is driven on the bus and loaded into the address register, and Z receives PC+1. In the next cycle, `mem_rd` is high for one cycle and `mem_addr` equals the old PC.
- R3: In step 2, Z is driven on the bus and loaded into the PC, so that after step 2 the PC is one higher than during step 1.
- R4: A read is outstanding from the cycle after its request until the cycle after `mem_done` is seen high. While it is outstanding, step 3, and step 5 of a load, hold the step counter and drive nothing onto the bus. This holds for any response delay, including the shortest one, where `mem_done` comes in the cycle after `mem_rd`.
- R5: In step 3, once no read is outstanding, the data register is driven on the bus and loaded into the instruction register.
- R6: Instruction encoding: bits [7:6] are the opcode (00 load, 01 add, 10 no-op, 11 halt). Bits [5:4] name the destination register Rd. Bits [3:2] name the source register Rs of an add. Bits [3:0] are the zero-extended load address.
- R7: A load runs in six steps. In step 4, the address field goes on the bus into the address register and a read is issued. Step 5 waits for the read. In step 6, the data register goes on the bus into Rd. The step counter then returns to step 1.
- R8: An add runs in six steps. In step 4, Rs goes on the bus into Y. In step 5, Rd goes on the bus and Z receives Y plus the bus. In step 6, Z goes on the bus into Rd. The sum wraps modulo 256, so 5 plus 10 gives 15 and 0xFF plus 10 gives 0x09.
- R9: A no-op ends in step 4, and the next cycle is step 1 of the next instruction.
- R10: A halt in step 4 sets `halted`. From then until reset, the step counter stays at 4, the PC does not change, no read is requested and no register is written.
- R11: At most one bus driver is enabled in any cycle. When none is enabled, `bus_o` is 0.
- R12: `reg_we` is high exactly in the cycle in which the register file loads from the bus, and `reg_wsel` then names the register written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_done | input | 1 | Read completion pulse from memory; `mem_rdata` is valid while it is high |
| mem_rdata | input | 8 | Read data from memory |
| mem_rd | output | 1 | One-cycle read request |
| mem_addr | output | 8 | Read address, taken from the address register |
| step_o | output | 3 | Current control step, 1 to 6 |
| halted | output | 1 | High after a halt instruction, until reset |
| pc_o | output | 8 | Program counter |
| ir_o | output | 8 | Instruction register |
| bus_o | output | 8 | Value on the shared bus |
| reg_we | output | 1 | Register file write in this cycle |
| reg_wsel | output | 2 | Destination register field of the current instruction |

## Verification
Every register in the block becomes visible on `bus_o` within a few steps of being written. A wrong PC, Z, Y, data register or register file entry therefore shows as a bus value mismatch no later than the end of the next instruction that reads it. A wrong step count or a missed stall shows in `step_o` and in the bus driver pattern in the very cycle it happens. The bench's behavioural model varies the memory delay from 0 to 3 cycles, one delay per read, and compares every output in every cycle. Errors in the outstanding-read flag are therefore caught in the first cycle in which the step counter should have held or moved.

// File: rtl/sbus_pkg.sv
// Shared types for the single-bus sequencer: opcode values and the control word.
// Assumes an instruction word whose top two bits are the opcode.
package sbus_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_ADD  = 2'b01,
        OP_NOP  = 2'b10,
        OP_HALT = 2'b11
    } op_e;

    // One control step's worth of enables.
    typedef struct packed {
        logic pc_out;    // bus drivers (at most one set)
        logic z_out;
        logic mdr_out;
        logic reg_out;
        logic ira_out;
        logic mar_in;    // bus loads
        logic pc_in;
        logic ir_in;
        logic y_in;
        logic z_in;
        logic reg_in;
        logic rd_start;  // issue a memory read
        logic alu_add;   // ALU: Y + bus when set, bus + 1 otherwise
        logic use_rs;    // register file reads Rs instead of Rd
        logic wait_mem;  // step holds while a read is outstanding
        logic last;      // final step of the instruction
        logic halt;      // stop the sequencer
    } ctrl_t;

endpackage

// File: rtl/sbus_seq.sv
// Step counter and control decoder.
// Produces the control word for the current step from the step number and opcode.
// Assumes: wfmc is high while a memory read is outstanding. A step with wait_mem
// set then holds and emits no enables. After a halt, all enables stay low until reset.
module sbus_seq
    import sbus_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic              wfmc,
    output ctrl_t             ctl,
    output logic [STEP_W-1:0] step,
    output logic              halted
);

    localparam logic [STEP_W-1:0] S1 = STEP_W'(1);
    localparam logic [STEP_W-1:0] S2 = STEP_W'(2);
    localparam logic [STEP_W-1:0] S3 = STEP_W'(3);
    localparam logic [STEP_W-1:0] S4 = STEP_W'(4);
    localparam logic [STEP_W-1:0] S5 = STEP_W'(5);
    localparam logic [STEP_W-1:0] S6 = STEP_W'(6);

    ctrl_t raw;
    logic  stall;

    // Decode the ungated control word for this step.
    always_comb begin
        raw = '0;
        case (step)
            S1: begin
                raw.pc_out   = 1'b1;
                raw.mar_in   = 1'b1;
                raw.rd_start = 1'b1;
                raw.z_in     = 1'b1;
            end
            S2: begin
                raw.z_out = 1'b1;
                raw.pc_in = 1'b1;
            end
            S3: begin
                raw.wait_mem = 1'b1;
                raw.mdr_out  = 1'b1;
                raw.ir_in    = 1'b1;
            end
            S4: begin
                case (op)
                    OP_LOAD: begin
                        raw.ira_out  = 1'b1;
                        raw.mar_in   = 1'b1;
                        raw.rd_start = 1'b1;
                    end
                    OP_ADD: begin
                        raw.reg_out = 1'b1;
                        raw.use_rs  = 1'b1;
                        raw.y_in    = 1'b1;
                    end
                    OP_NOP:  raw.last = 1'b1;
                    default: raw.halt = 1'b1;
                endcase
            end
            S5: begin
                if (op == OP_LOAD) begin
                    raw.wait_mem = 1'b1;
                end else begin
                    raw.reg_out = 1'b1;
                    raw.alu_add = 1'b1;
                    raw.z_in    = 1'b1;
                end
            end
            S6: begin
                raw.reg_in = 1'b1;
                raw.last   = 1'b1;
                if (op == OP_LOAD) raw.mdr_out = 1'b1;
                else               raw.z_out   = 1'b1;
            end
            default: raw.last = 1'b1;
        endcase
    end

    // Suppress all enables while waiting on memory or after a halt.
    always_comb begin
        stall = raw.wait_mem & wfmc;
        ctl   = (stall || halted) ? '0 : raw;
    end

    // Advance, wrap or freeze the step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step   <= S1;
            halted <= 1'b0;
        end else if (!halted && !stall) begin
            if (raw.halt)      halted <= 1'b1;
            else if (raw.last) step   <= S1;
            else               step   <= step + STEP_W'(1);
        end
    end

endmodule

// File: rtl/sbus_alu.sv
// ALU with operand latch Y and result register Z.
// Z takes either bus+1 (PC increment) or Y+bus (add). Sums wrap at the data width.
module sbus_alu #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus,
    input  logic              y_in,
    input  logic              z_in,
    input  logic              add,
    output logic [DATA_W-1:0] z
);

    logic [DATA_W-1:0] y;
    logic [DATA_W-1:0] result;

    // Select the ALU function.
    always_comb begin
        result = add ? (y + bus) : (bus + DATA_W'(1));
    end

    // Latch the first operand and the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y <= '0;
            z <= '0;
        end else begin
            if (y_in) y <= bus;
            if (z_in) z <= result;
        end
    end

endmodule

// File: rtl/sbus_regfile.sv
// General register file: one read port and one write port, both from or to the bus.
// Assumes the write select is stable in the write cycle. All entries clear on reset.
module sbus_regfile #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  wsel,
    input  logic [SEL_W-1:0]  rsel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int NREG = 1 << SEL_W;

    logic [DATA_W-1:0] regs [NREG];

    // Clear on reset, otherwise write the selected entry.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n)                               regs[i] <= '0;
            else if (we && (wsel == SEL_W'(i)))       regs[i] <= wdata;
        end
    end

    // Combinational read.
    always_comb begin
        rdata = regs[rsel];
    end

endmodule

// File: rtl/sbus_dpath.sv
// Single-bus datapath: PC, MAR, MDR, IR, ALU and register file around one bus.
// It also holds the outstanding-read flag that the sequencer waits on.
// Assumes at most one driver enable is set per cycle; the bus is the OR of gated sources.
module sbus_dpath
    import sbus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctl,
    input  logic              mem_done,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] bus,
    output logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] ir,
    output logic [DATA_W-1:0] mar,
    output logic              mem_rd,
    output logic              wfmc,
    output logic [SEL_W-1:0]  rd_sel
);

    localparam int RD_LSB  = DATA_W - 2 - SEL_W;
    localparam int RS_LSB  = RD_LSB - SEL_W;
    localparam int ADDRF_W = RD_LSB;

    logic [DATA_W-1:0] mdr;
    logic [DATA_W-1:0] z;
    logic [DATA_W-1:0] rf_rdata;
    logic [DATA_W-1:0] ir_addr;
    logic [SEL_W-1:0]  rs_sel;
    logic [SEL_W-1:0]  rf_rsel;
    logic              unused_ctl;

    // Instruction fields and the register read select.
    always_comb begin
        rd_sel     = ir[RD_LSB +: SEL_W];
        rs_sel     = ir[RS_LSB +: SEL_W];
        ir_addr    = {{(DATA_W-ADDRF_W){1'b0}}, ir[ADDRF_W-1:0]};
        rf_rsel    = ctl.use_rs ? rs_sel : rd_sel;
        unused_ctl = ^{ctl.wait_mem, ctl.last, ctl.halt};
    end

    // Shared bus: OR of the gated sources.
    always_comb begin
        bus = ({DATA_W{ctl.pc_out}}  & pc)
            | ({DATA_W{ctl.z_out}}   & z)
            | ({DATA_W{ctl.mdr_out}} & mdr)
            | ({DATA_W{ctl.reg_out}} & rf_rdata)
            | ({DATA_W{ctl.ira_out}} & ir_addr);
    end

    // PC, MAR, IR loads from the bus; MDR capture and read tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= '0;
            mar    <= '0;
            ir     <= '0;
            mdr    <= '0;
            wfmc   <= 1'b0;
            mem_rd <= 1'b0;
        end else begin
            if (ctl.pc_in)  pc  <= bus;
            if (ctl.mar_in) mar <= bus;
            if (ctl.ir_in)  ir  <= bus;
            if (mem_done && wfmc) mdr <= mem_rdata;
            if (ctl.rd_start)     wfmc <= 1'b1;
            else if (mem_done)    wfmc <= 1'b0;
            mem_rd <= ctl.rd_start;
        end
    end

    sbus_alu #(.DATA_W(DATA_W)) u_alu (
        .clk   (clk),
        .rst_n (rst_n),
        .bus   (bus),
        .y_in  (ctl.y_in),
        .z_in  (ctl.z_in),
        .add   (ctl.alu_add),
        .z     (z)
    );

    sbus_regfile #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl.reg_in),
        .wsel  (rd_sel),
        .rsel  (rf_rsel),
        .wdata (bus),
        .rdata (rf_rdata)
    );

endmodule

// File: rtl/sbus_cpu.sv
// Top of the single-bus control sequencer with its datapath.
// Assumes an external memory that answers each one-cycle mem_rd with a mem_done
// pulse carrying the data, after any number of cycles.
module sbus_cpu
    import sbus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 2,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_done,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic [DATA_W-1:0] mem_addr,
    output logic [STEP_W-1:0] step_o,
    output logic              halted,
    output logic [DATA_W-1:0] pc_o,
    output logic [DATA_W-1:0] ir_o,
    output logic [DATA_W-1:0] bus_o,
    output logic              reg_we,
    output logic [SEL_W-1:0]  reg_wsel
);

    ctrl_t ctl;
    logic  wfmc;
    op_e   op;

    // Opcode from the top of the instruction register.
    always_comb begin
        op     = op_e'(ir_o[DATA_W-1 -: 2]);
        reg_we = ctl.reg_in;
    end

    sbus_seq #(.STEP_W(STEP_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .wfmc   (wfmc),
        .ctl    (ctl),
        .step   (step_o),
        .halted (halted)
    );

    sbus_dpath #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_done  (mem_done),
        .mem_rdata (mem_rdata),
        .bus       (bus_o),
        .pc        (pc_o),
        .ir        (ir_o),
        .mar       (mem_addr),
        .mem_rd    (mem_rd),
        .wfmc      (wfmc),
        .rd_sel    (reg_wsel)
    );

endmodule

// File: rtl/sbus_cpu_chk.sv
// Property checker for sbus_cpu, attached by bind. Observes only; drives nothing.
module sbus_cpu_chk
    import sbus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STEP_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input ctrl_t             ctl,
    input logic              wfmc,
    input logic [STEP_W-1:0] step_o,
    input logic              halted,
    input logic [DATA_W-1:0] pc_o,
    input logic [DATA_W-1:0] ir_o,
    input logic              mem_rd,
    input logic [DATA_W-1:0] mem_addr
);

    assert_one_driver_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl.pc_out, ctl.z_out, ctl.mdr_out, ctl.reg_out, ctl.ira_out}));

    assert_mar_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == STEP_W'(1) && !halted) |=> (mem_rd && mem_addr == $past(pc_o)));

    assert_pc_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == STEP_W'(2) && !halted) |=> (pc_o == DATA_W'($past(pc_o) + 1'b1)));

    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == STEP_W'(3) && wfmc) |=> (step_o == STEP_W'(3)));

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == STEP_W'(6)) |=> (step_o == STEP_W'(1)));

    assert_nop_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == STEP_W'(4) && ir_o[DATA_W-1 -: 2] == 2'b10 && !halted)
        |=> (step_o == STEP_W'(1)));

    assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(step_o) && $stable(pc_o) && !mem_rd));

endmodule

bind sbus_cpu sbus_cpu_chk #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .wfmc     (wfmc),
    .step_o   (step_o),
    .halted   (halted),
    .pc_o     (pc_o),
    .ir_o     (ir_o),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr)
);

// File: tb/sbus_cpu_tb.sv
// Bench: behavioural reference model compared with every output on every clock.
// Memory delay cycles 0..3 across successive reads.
module sbus_cpu_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mem_done;
    logic [7:0] mem_rdata;
    logic       mem_rd;
    logic [7:0] mem_addr;
    logic [2:0] step_o;
    logic       halted;
    logic [7:0] pc_o;
    logic [7:0] ir_o;
    logic [7:0] bus_o;
    logic       reg_we;
    logic [1:0] reg_wsel;

    always #10 clk = ~clk;

    sbus_cpu u_dut (
        .clk(clk), .rst_n(rst_n), .mem_done(mem_done), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .step_o(step_o), .halted(halted),
        .pc_o(pc_o), .ir_o(ir_o), .bus_o(bus_o), .reg_we(reg_we), .reg_wsel(reg_wsel)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Memory and model state.
    logic [7:0] mem [256];
    int         m_step, m_pc, m_mar, m_mdr, m_ir, m_y, m_z;
    int         m_reg [4];
    bit         m_pend, m_rdq, m_halt;
    bit         busy;
    int         wcnt, raddr, nreads;
    int         obs [4];
    int         nwr [4];

    task automatic model_reset();
        m_step = 1; m_pc = 0; m_mar = 0; m_mdr = 0; m_ir = 0; m_y = 0; m_z = 0;
        for (int i = 0; i < 4; i++) m_reg[i] = 0;
        m_pend = 0; m_rdq = 0; m_halt = 0; busy = 0; wcnt = 0;
    endtask

    // One cycle at the falling edge: memory response, compare, next state.
    task automatic cycle();
        int  op, rd, rs, ebus, nstep;
        bit  done, stall, ewe, rdst;
        op = (m_ir >> 6) & 3; rd = (m_ir >> 4) & 3; rs = (m_ir >> 2) & 3;
        done = 0;
        if (busy) begin
            if (wcnt == 0) begin done = 1; busy = 0; end
            else wcnt--;
        end
        if (m_rdq) begin
            busy = 1; wcnt = nreads % 4; raddr = m_mar; nreads++;
        end
        mem_done  = done;
        mem_rdata = done ? mem[raddr] : 8'h00;

        stall = !m_halt && (m_step == 3 || (m_step == 5 && op == 0)) && m_pend;
        ebus = 0; ewe = 0;
        if (!m_halt && !stall) begin
            case (m_step)
                1: ebus = m_pc;
                2: ebus = m_z;
                3: ebus = m_mdr;
                4: ebus = (op == 0) ? (m_ir & 15) : (op == 1) ? m_reg[rs] : 0;
                5: ebus = (op == 1) ? m_reg[rd] : 0;
                6: begin ebus = (op == 0) ? m_mdr : m_z; ewe = 1; end
                default: ebus = 0;
            endcase
        end
        // R4 stall, R7/R9 step sequence
        chk("R4,R7,R9", "step", 32'(step_o), 32'(m_step));
        chk("R3", "pc", 32'(pc_o), 32'(m_pc));
        chk("R5", "ir", 32'(ir_o), 32'(m_ir));
        chk("R10", "halted", 32'(halted), 32'(m_halt));
        chk("R11,R6,R8", "bus", 32'(bus_o), 32'(ebus));
        chk("R2", "mem_rd", 32'(mem_rd), 32'(m_rdq));
        chk("R2", "mem_addr", 32'(mem_addr), 32'(m_mar));
        chk("R12", "reg_we", 32'(reg_we), 32'(ewe));
        if (ewe) begin
            chk("R12", "reg_wsel", 32'(reg_wsel), 32'(rd));
            if (nwr[rd] == 0 && rd == 3)  // first R3 write is 0+0: regs cleared by reset
                chk("R1", "reset reg value", 32'(bus_o), 32'h0);
            obs[rd] = bus_o; nwr[rd]++;
        end

        rdst = 0; nstep = m_step;
        if (!m_halt && !stall) begin
            case (m_step)
                1: begin m_mar = m_pc; m_z = (m_pc + 1) & 255; rdst = 1; nstep = 2; end
                2: begin m_pc = m_z; nstep = 3; end
                3: begin m_ir = m_mdr; nstep = 4; end
                4: begin
                    if (op == 0)      begin m_mar = m_ir & 15; rdst = 1; nstep = 5; end
                    else if (op == 1) begin m_y = m_reg[rs]; nstep = 5; end
                    else if (op == 2) nstep = 1;  // R9 no-op ends here
                    else m_halt = 1;               // R10
                end
                5: begin
                    if (op == 1) m_z = (m_y + m_reg[rd]) & 255;
                    nstep = 6;
                end
                default: begin m_reg[rd] = (op == 0) ? m_mdr : m_z; nstep = 1; end
            endcase
        end
        m_step = nstep;
        if (done && m_pend) m_mdr = mem_rdata;
        if (rdst)      m_pend = 1;
        else if (done) m_pend = 0;
        m_rdq = rdst;
    endtask

    initial begin
        int cyc, after;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        // R6 encodings
        mem[0] = 8'h1C;  // load R1,[12]
        mem[1] = 8'h2D;  // load R2,[13]
        mem[2] = 8'h58;  // add R1,R2 -> 15
        mem[3] = 8'h80;  // nop
        mem[4] = 8'h7C;  // add R3,R3 -> 0
        mem[5] = 8'h3E;  // load R3,[14]
        mem[6] = 8'h74;  // add R3,R1 -> 0xFF
        mem[7] = 8'h78;  // add R3,R2 -> 0x09 (wrap)
        mem[8] = 8'h44;  // add R0,R1 -> 15
        mem[9] = 8'hC0;  // halt
        mem[12] = 8'd5; mem[13] = 8'd10; mem[14] = 8'hF0;
        for (int i = 0; i < 4; i++) begin obs[i] = -1; nwr[i] = 0; end
        nreads = 0;
        rst_n = 1'b0; mem_done = 1'b0; mem_rdata = 8'h00;
        model_reset();
        repeat (3) @(negedge clk);
        chk("R1", "reset step", 32'(step_o), 32'd1);
        chk("R1", "reset pc", 32'(pc_o), 32'd0);
        chk("R1", "reset halted", 32'(halted), 32'd0);
        chk("R1", "reset mem_rd", 32'(mem_rd), 32'd0);
        rst_n = 1'b1;
        cyc = 0; after = 0;
        while (after < 20 && cyc < 2000) begin
            cycle();
            if (m_halt) after++;
            cyc++;
            @(negedge clk);
        end
        if (cyc >= 2000) chk("R10", "watchdog expired", 32'd1, 32'd0);
        chk("R8", "R1 = 5+10", 32'(obs[1]), 32'd15);
        chk("R7", "R2 loaded", 32'(obs[2]), 32'd10);
        chk("R8", "R3 wraps", 32'(obs[3]), 32'h09);
        chk("R8", "R0 = R1", 32'(obs[0]), 32'd15);
        chk("R10", "halt pc frozen", 32'(pc_o), 32'd10);
        chk("R10", "halt step", 32'(step_o), 32'd4);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "re-reset step", 32'(step_o), 32'd1);
        chk("R1", "re-reset pc", 32'(pc_o), 32'd0);
        chk("R1", "re-reset halted", 32'(halted), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule